// File: doc/BRIEF.md
# Ring Header Control and Status Register File

This block is the per-ring register file of a host controller. The controller moves commands, their responses and in-band interrupt records through circular rings kept in system memory. Software reaches the block over a plain 32-bit register bus with separate read and write strobes. A read returns its data one clock after the strobe. The block holds the ring's enable, run/stop and abort controls, and reports whether the ring is enabled, running, aborted or locked. It keeps the producer and consumer indices for the command ring and for the interrupt-record ring. It latches interrupt causes through a status-enable mask and drives a single interrupt line through a signal-enable mask.

Software owns some pointer fields and hardware owns the others. The software fields sit in one packed register. The hardware fields sit in a second packed register that software can only read. A small hardware-side stub stands in for the bus engine. Each pulse on its completion input retires one command. Each pulse on its record input appends one interrupt record. Enabling or aborting the ring raises a ring-operation interrupt, so software can wait for the operation to finish.

Top module: `ring_hdr_regs`

## Requirements
- R1: After a synchronous reset, the control register reads 0, the ring status reads 0, the interrupt status reads 0, every pointer reads 0, the entry count reads 0, `irq` is low and `cmd_full` is low.
- R2: The register at offset 0x00 reads back the written entry count in bits [8:0]. Bits [31:24] read the fixed transfer-structure size (XFER_SZ, default 16) and bits [23:16] read the fixed response-structure size (RESP_SZ, default 4); writes cannot change them. The register at offset 0x04 reads back the record-ring entry count in [23:16], the chunk size code in [12:10] and the chunk count in [9:0], with the fixed record size (IBI_SZ, default 8) in [31:24]. The register at offset 0x08 is a plain 32-bit read/write register.
- R3: The register at offset 0x28 takes only three software fields: the record-ring consumer index in [23:16], the command software consumer index in [15:8] and the command producer index in [7:0]. Bits [31:24] always read 0.
- R4: The register at offset 0x2C is read-only. It shows the record-ring producer index in [23:16] and the hardware command consumer index in [7:0]; all other bits read 0.
- R5: While the ring is running, each `hw_cmd_done` pulse advances the hardware command consumer index by one, wrapping to 0 at the entry count. A pulse is ignored when that index already equals the command producer index.
- R6: A retired command with `hw_cmd_ioc` high sets interrupt status bit 11. A retired command with `hw_cmd_err` high sets bit 9.
- R7: A hardware cause sets its interrupt status bit (bits 12, 11, 10, 9, 7, 6, 5, offset 0x10) only if the matching bit of the status-enable register (offset 0x14) is 1. The enable register keeps only those seven bits.
- R8: `irq` is high exactly one clock after some interrupt status bit is set together with its bit in the signal-enable register (offset 0x18). The signal-enable register keeps only the seven cause bits.
- R9: Writing 1 to an interrupt status bit clears it; writing 0 leaves it unchanged.
- R10: Writing the force register (offset 0x1C) sets the written cause bits in the status register regardless of status-enable. The force register reads 0.
- R11: Ring control at offset 0x24 uses bit 0 for enable, bit 1 for run/stop and bit 2 for abort. Ring status at offset 0x20 uses bit 0 for enabled, bit 1 for running, bit 2 for aborted and bit 3 for locked. Writing abort sets aborted and locked, stops the ring and raises status bit 10. A later write of enable without abort clears aborted, restarts the ring and raises bit 10 again.
- R12: `cmd_full` is high when advancing the command producer index, modulo the entry count, would make it equal to the hardware command consumer index.
- R13: Each `hw_ibi_push` pulse advances the record-ring producer index modulo its entry count and sets status bit 12. If advancing would make the producer index equal to the record-ring consumer index, the push is dropped, the producer index holds and bit 6 is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after `bus_rd` |
| hw_cmd_done | input | 1 | Stub: one command has finished |
| hw_cmd_ioc | input | 1 | Stub: the finished command asked for a completion interrupt |
| hw_cmd_err | input | 1 | Stub: the finished command ended in error |
| hw_ibi_push | input | 1 | Stub: one interrupt record has arrived |
| cmd_full | output | 1 | Command ring has no free slot |
| irq | output | 1 | Interrupt request, registered |

## Verification
A wrong pointer shows up on the next read of offset 0x2C. It also shows on `cmd_full` in the same clock, because that flag compares the producer index with the hardware consumer index. A lost or spurious interrupt cause shows in the status register at the edge of the event and on `irq` one clock later. A bad masking path is caught by raising a cause with its status-enable bit or signal-enable bit cleared and confirming that nothing changes. Abort handling is checked by retiring a command while the ring is aborted and confirming that the consumer index stays put.

// File: rtl/ring_hdr_pkg.sv
package ring_hdr_pkg;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int PW = 8;
  localparam int CW = 9;

  localparam logic [AW-1:0] OFS_SETUP   = 8'h00;
  localparam logic [AW-1:0] OFS_REC_SET = 8'h04;
  localparam logic [AW-1:0] OFS_CHUNK   = 8'h08;
  localparam logic [AW-1:0] OFS_ISTAT   = 8'h10;
  localparam logic [AW-1:0] OFS_IEN     = 8'h14;
  localparam logic [AW-1:0] OFS_ISIG    = 8'h18;
  localparam logic [AW-1:0] OFS_IFORCE  = 8'h1C;
  localparam logic [AW-1:0] OFS_RSTAT   = 8'h20;
  localparam logic [AW-1:0] OFS_RCTL    = 8'h24;
  localparam logic [AW-1:0] OFS_OPSW    = 8'h28;
  localparam logic [AW-1:0] OFS_OPHW    = 8'h2C;

  localparam int CB_REC_RDY  = 12;
  localparam int CB_XFER_OK  = 11;
  localparam int CB_RING_OP  = 10;
  localparam int CB_XFER_ERR = 9;
  localparam int CB_STOP_INS = 7;
  localparam int CB_REC_FULL = 6;
  localparam int CB_XFER_ABT = 5;

  localparam logic [DW-1:0] CAUSE_MASK = 32'h0000_1EE0;

  localparam int CTL_EN  = 0;
  localparam int CTL_RUN = 1;
  localparam int CTL_ABT = 2;

  typedef struct packed {
    logic locked;
    logic aborted;
    logic running;
    logic enabled;
  } ring_stat_t;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p,
                                             input logic [CW-1:0] n);
    logic [CW-1:0] s;
    s = {1'b0, p} + 1'b1;
    return (s == n) ? '0 : s[PW-1:0];
  endfunction

endpackage

// File: rtl/ring_ctrl_unit.sv
module ring_ctrl_unit
  import ring_hdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wdata,
  output logic [2:0]       ctl_q,
  output ring_stat_t       stat,
  output logic             ring_run,
  output logic             ev_ring_op
);

  logic enabled_q;
  logic aborted_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      enabled_q <= 1'b0;
      aborted_q <= 1'b0;
    end else if (wr_en) begin
      ctl_q     <= wdata;
      enabled_q <= wdata[CTL_EN];
      if (wdata[CTL_ABT])
        aborted_q <= 1'b1;
      else if (wdata[CTL_EN])
        aborted_q <= 1'b0;
    end
  end

  assign ev_ring_op    = wr_en & (wdata[CTL_EN] | wdata[CTL_ABT]);
  assign ring_run      = enabled_q & ~aborted_q;
  assign stat.enabled  = enabled_q;
  assign stat.running  = ring_run;
  assign stat.aborted  = aborted_q;
  assign stat.locked   = aborted_q;

  AST_ABORT_HALTS: assert property (@(posedge clk) disable iff (rst)
    wr_en && wdata[CTL_ABT] |=> !ring_run && stat.aborted); // R11

  AST_ENABLE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    wr_en && wdata[CTL_EN] && !wdata[CTL_ABT] |=> ring_run); // R11

endmodule

// File: rtl/ring_ptr_unit.sv
module ring_ptr_unit
  import ring_hdr_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           sw_wr,
  input  logic [23:0]    sw_wdata,
  input  logic [CW-1:0]  cmd_cnt,
  input  logic [PW-1:0]  rec_cnt,
  input  logic           ring_run,
  input  logic           hw_cmd_done,
  input  logic           hw_cmd_ioc,
  input  logic           hw_cmd_err,
  input  logic           hw_ibi_push,
  output logic [PW-1:0]  rec_deq,
  output logic [PW-1:0]  sw_deq,
  output logic [PW-1:0]  cmd_enq,
  output logic [PW-1:0]  hw_deq,
  output logic [PW-1:0]  rec_enq,
  output logic           cmd_full,
  output logic           ev_xfer_ok,
  output logic           ev_xfer_err,
  output logic           ev_rec_rdy,
  output logic           ev_rec_full
);

  logic          cmd_take;
  logic          rec_room;
  logic          rec_take;
  logic [PW-1:0] rec_nx;

  assign cmd_take = hw_cmd_done & ring_run & (hw_deq != cmd_enq);
  assign rec_nx   = ptr_next(rec_enq, {1'b0, rec_cnt});
  assign rec_room = (rec_nx != rec_deq);
  assign rec_take = hw_ibi_push & rec_room;

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_deq <= '0;
      sw_deq  <= '0;
      cmd_enq <= '0;
    end else if (sw_wr) begin
      rec_deq <= sw_wdata[23:16];
      sw_deq  <= sw_wdata[15:8];
      cmd_enq <= sw_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_deq  <= '0;
      rec_enq <= '0;
    end else begin
      if (cmd_take) hw_deq  <= ptr_next(hw_deq, cmd_cnt);
      if (rec_take) rec_enq <= rec_nx;
    end
  end

  assign cmd_full    = (ptr_next(cmd_enq, cmd_cnt) == hw_deq);
  assign ev_xfer_ok  = cmd_take & hw_cmd_ioc;
  assign ev_xfer_err = cmd_take & hw_cmd_err;
  assign ev_rec_rdy  = rec_take;
  assign ev_rec_full = hw_ibi_push & ~rec_room;

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    hw_cmd_done && hw_deq == cmd_enq |=> $stable(hw_deq)); // R5

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !ring_run |=> $stable(hw_deq)); // R11

  AST_REC_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    hw_ibi_push && !rec_room |=> $stable(rec_enq)); // R13

endmodule

// File: rtl/ring_irq_unit.sv
module ring_irq_unit
  import ring_hdr_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  ev,
  input  logic           en_wr,
  input  logic           sig_wr,
  input  logic           stat_wr,
  input  logic           force_wr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  stat_q,
  output logic [DW-1:0]  en_q,
  output logic [DW-1:0]  sig_q,
  output logic           irq_o
);

  logic [DW-1:0] set_v;
  logic [DW-1:0] clr_v;

  assign set_v = ((ev & en_q) | (force_wr ? wdata : '0)) & CAUSE_MASK;
  assign clr_v = stat_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
      sig_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_v) | set_v;
      if (en_wr)  en_q  <= wdata & CAUSE_MASK;
      if (sig_wr) sig_q <= wdata & CAUSE_MASK;
      irq_o <= |(stat_q & sig_q);
    end
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    stat_wr && ((ev & en_q) == '0) && !force_wr
      |=> (stat_q & $past(wdata) & CAUSE_MASK) == '0); // R9

  AST_MASKED_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !force_wr && en_q == '0 && stat_q == '0 |=> stat_q == '0); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (stat_q & sig_q) == '0 |=> !irq_o); // R8

  AST_FORCE_SETS: assert property (@(posedge clk) disable iff (rst)
    force_wr && !stat_wr |=> (stat_q & $past(wdata) & CAUSE_MASK)
      == ($past(wdata) & CAUSE_MASK)); // R10

endmodule

// File: rtl/ring_hdr_regs.sv
module ring_hdr_regs
  import ring_hdr_pkg::*;
#(
  parameter int XFER_SZ = 16,
  parameter int RESP_SZ = 4,
  parameter int IBI_SZ  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          hw_cmd_done,
  input  logic          hw_cmd_ioc,
  input  logic          hw_cmd_err,
  input  logic          hw_ibi_push,
  output logic          cmd_full,
  output logic          irq
);

  localparam logic [7:0] XSZ = XFER_SZ[7:0];
  localparam logic [7:0] RSZ = RESP_SZ[7:0];
  localparam logic [7:0] ISZ = IBI_SZ[7:0];

  logic [CW-1:0] cmd_cnt_q;
  logic [PW-1:0] rec_cnt_q;
  logic [2:0]    chunk_sz_q;
  logic [9:0]    chunk_cnt_q;
  logic [DW-1:0] chunk_ctl_q;

  logic w_setup, w_rec, w_chunk, w_stat, w_en, w_sig, w_force, w_ctl, w_opsw;

  assign w_setup = bus_wr && bus_addr == OFS_SETUP;
  assign w_rec   = bus_wr && bus_addr == OFS_REC_SET;
  assign w_chunk = bus_wr && bus_addr == OFS_CHUNK;
  assign w_stat  = bus_wr && bus_addr == OFS_ISTAT;
  assign w_en    = bus_wr && bus_addr == OFS_IEN;
  assign w_sig   = bus_wr && bus_addr == OFS_ISIG;
  assign w_force = bus_wr && bus_addr == OFS_IFORCE;
  assign w_ctl   = bus_wr && bus_addr == OFS_RCTL;
  assign w_opsw  = bus_wr && bus_addr == OFS_OPSW;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_cnt_q   <= '0;
      rec_cnt_q   <= '0;
      chunk_sz_q  <= '0;
      chunk_cnt_q <= '0;
      chunk_ctl_q <= '0;
    end else begin
      if (w_setup) cmd_cnt_q <= bus_wdata[CW-1:0];
      if (w_rec) begin
        rec_cnt_q   <= bus_wdata[23:16];
        chunk_sz_q  <= bus_wdata[12:10];
        chunk_cnt_q <= bus_wdata[9:0];
      end
      if (w_chunk) chunk_ctl_q <= bus_wdata;
    end
  end

  logic [2:0]  ctl_q;
  ring_stat_t  rstat;
  logic        ring_run;
  logic        ev_ring_op;

  ring_ctrl_unit u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (w_ctl),
    .wdata      (bus_wdata[2:0]),
    .ctl_q      (ctl_q),
    .stat       (rstat),
    .ring_run   (ring_run),
    .ev_ring_op (ev_ring_op)
  );

  logic [PW-1:0] rec_deq, sw_deq, cmd_enq, hw_deq, rec_enq;
  logic          ev_xfer_ok, ev_xfer_err, ev_rec_rdy, ev_rec_full;

  ring_ptr_unit u_ptr (
    .clk         (clk),
    .rst         (rst),
    .sw_wr       (w_opsw),
    .sw_wdata    (bus_wdata[23:0]),
    .cmd_cnt     (cmd_cnt_q),
    .rec_cnt     (rec_cnt_q),
    .ring_run    (ring_run),
    .hw_cmd_done (hw_cmd_done),
    .hw_cmd_ioc  (hw_cmd_ioc),
    .hw_cmd_err  (hw_cmd_err),
    .hw_ibi_push (hw_ibi_push),
    .rec_deq     (rec_deq),
    .sw_deq      (sw_deq),
    .cmd_enq     (cmd_enq),
    .hw_deq      (hw_deq),
    .rec_enq     (rec_enq),
    .cmd_full    (cmd_full),
    .ev_xfer_ok  (ev_xfer_ok),
    .ev_xfer_err (ev_xfer_err),
    .ev_rec_rdy  (ev_rec_rdy),
    .ev_rec_full (ev_rec_full)
  );

  logic [DW-1:0] ev_vec;
  logic [DW-1:0] stat_q, en_q, sig_q;

  always_comb begin
    ev_vec              = '0;
    ev_vec[CB_REC_RDY]  = ev_rec_rdy;
    ev_vec[CB_XFER_OK]  = ev_xfer_ok;
    ev_vec[CB_RING_OP]  = ev_ring_op;
    ev_vec[CB_XFER_ERR] = ev_xfer_err;
    ev_vec[CB_REC_FULL] = ev_rec_full;
  end

  ring_irq_unit u_irq (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev_vec),
    .en_wr    (w_en),
    .sig_wr   (w_sig),
    .stat_wr  (w_stat),
    .force_wr (w_force),
    .wdata    (bus_wdata),
    .stat_q   (stat_q),
    .en_q     (en_q),
    .sig_q    (sig_q),
    .irq_o    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_SETUP:   bus_rdata <= {XSZ, RSZ, 7'b0, cmd_cnt_q};
        OFS_REC_SET: bus_rdata <= {ISZ, rec_cnt_q, 3'b0, chunk_sz_q, chunk_cnt_q};
        OFS_CHUNK:   bus_rdata <= chunk_ctl_q;
        OFS_ISTAT:   bus_rdata <= stat_q;
        OFS_IEN:     bus_rdata <= en_q;
        OFS_ISIG:    bus_rdata <= sig_q;
        OFS_RSTAT:   bus_rdata <= {28'b0, rstat};
        OFS_RCTL:    bus_rdata <= {29'b0, ctl_q};
        OFS_OPSW:    bus_rdata <= {8'b0, rec_deq, sw_deq, cmd_enq};
        OFS_OPHW:    bus_rdata <= {8'b0, rec_enq, 8'b0, hw_deq};
        default:     bus_rdata <= '0;
      endcase
    end
  end

  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    cmd_full && cmd_cnt_q > 1 |-> hw_deq != cmd_enq); // R12

endmodule

// File: tb/tb_ring_hdr_regs.sv
module tb_ring_hdr_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hw_cmd_done = 1'b0;
  logic        hw_cmd_ioc = 1'b0;
  logic        hw_cmd_err = 1'b0;
  logic        hw_ibi_push = 1'b0;
  logic        cmd_full;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ring_hdr_regs dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_cmd_done(hw_cmd_done), .hw_cmd_ioc(hw_cmd_ioc),
    .hw_cmd_err(hw_cmd_err), .hw_ibi_push(hw_ibi_push),
    .cmd_full(cmd_full), .irq(irq)
  );

  // {offset, write data, expected read-back}
  localparam logic [71:0] VEC [11] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h1004_01FF},
    {8'h00, 32'h0000_0010, 32'h1004_0010},
    {8'h04, 32'hFFFF_FFFF, 32'h08FF_1FFF},
    {8'h04, 32'h0004_0000, 32'h0804_0000},
    {8'h08, 32'h1234_5678, 32'h1234_5678},
    {8'h14, 32'hFFFF_FFFF, 32'h0000_1EE0},
    {8'h18, 32'hFFFF_FFFF, 32'h0000_1EE0},
    {8'h1C, 32'h0000_0000, 32'h0000_0000},
    {8'h28, 32'hFFFF_FFFF, 32'h00FF_FFFF},
    {8'h28, 32'h0000_0000, 32'h0000_0000},
    {8'h2C, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic done_pulse(input logic ioc, input logic err);
    @(negedge clk);
    hw_cmd_done = 1'b1; hw_cmd_ioc = ioc; hw_cmd_err = err;
    @(negedge clk);
    hw_cmd_done = 1'b0; hw_cmd_ioc = 1'b0; hw_cmd_err = 1'b0;
  endtask

  task automatic push_pulse();
    @(negedge clk);
    hw_ibi_push = 1'b1;
    @(negedge clk);
    hw_ibi_push = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 cmd_full", {31'b0, cmd_full}, 32'h0);
    rd(8'h00, r); check("R1 setup", r, 32'h1004_0000);
    rd(8'h24, r); check("R1 control", r, 32'h0);
    rd(8'h20, r); check("R1 ring status", r, 32'h0);
    rd(8'h10, r); check("R1 intr status", r, 32'h0);
    rd(8'h28, r); check("R1 sw ptrs", r, 32'h0);
    rd(8'h2C, r); check("R1 hw ptrs", r, 32'h0);

    // table: R2 setup/record/chunk, R7 enable mask, R8 signal mask,
    // R10 force reads 0, R3 sw pointer fields, R4 read-only hw pointers
    for (int i = 0; i < 11; i++) begin
      string tag;
      case (VEC[i][71:64])
        8'h14:   tag = "R7 enable readback";
        8'h18:   tag = "R8 signal readback";
        8'h1C:   tag = "R10 force readback";
        8'h28:   tag = "R3 sw pointer fields";
        8'h2C:   tag = "R4 hw pointers read-only";
        default: tag = "R2 setup readback";
      endcase
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], r);
      check(tag, r, VEC[i][31:0]);
    end

    // R11 enable raises ring-op
    wr(8'h24, 32'h1);
    rd(8'h20, r); check("R11 enabled+running", r, 32'h3);
    rd(8'h10, r); check("R11 ring-op on enable", r, 32'h400);
    check("R8 irq raised", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h400);
    rd(8'h10, r); check("R9 w1c clears", r, 32'h0);
    idle();
    check("R9 irq drops", {31'b0, irq}, 32'h0);

    // R5 / R6 completion
    wr(8'h28, 32'h3);
    done_pulse(1'b0, 1'b0);
    rd(8'h2C, r); check("R5 deq advance", r, 32'h1);
    rd(8'h10, r); check("R6 no ioc no status", r, 32'h0);
    done_pulse(1'b1, 1'b0);
    rd(8'h2C, r); check("R5 deq advance 2", r, 32'h2);
    rd(8'h10, r); check("R6 ioc sets bit 11", r, 32'h800);
    done_pulse(1'b0, 1'b1);
    rd(8'h10, r); check("R6 err sets bit 9", r, 32'hA00);
    wr(8'h10, 32'h200);
    rd(8'h10, r); check("R9 partial clear", r, 32'h800);
    wr(8'h10, 32'h800);
    done_pulse(1'b1, 1'b0);
    rd(8'h2C, r); check("R5 empty ignored", r, 32'h3);
    rd(8'h10, r); check("R5 empty no event", r, 32'h0);

    // R5 wrap at entry count 16
    wr(8'h28, 32'h1);
    for (int k = 0; k < 14; k++) done_pulse(1'b0, 1'b0);
    rd(8'h2C, r); check("R5 wrap", r, 32'h1);
    check("R12 not full", {31'b0, cmd_full}, 32'h0);
    wr(8'h28, 32'h0);
    check("R12 full", {31'b0, cmd_full}, 32'h1);
    wr(8'h28, 32'h2);
    check("R12 room again", {31'b0, cmd_full}, 32'h0);

    // R7 masked cause
    wr(8'h14, 32'h0);
    done_pulse(1'b1, 1'b1);
    rd(8'h2C, r); check("R7 command retired", r, 32'h2);
    rd(8'h10, r); check("R7 masked no status", r, 32'h0);
    idle();
    check("R7 irq low", {31'b0, irq}, 32'h0);

    // R10 force, R8 signal enable
    wr(8'h1C, 32'h200);
    rd(8'h10, r); check("R10 force sets", r, 32'h200);
    wr(8'h18, 32'h0);
    idle();
    check("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(8'h18, 32'h200);
    idle();
    check("R8 irq unmasked", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h200);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);

    // R11 abort and restart
    wr(8'h28, 32'h3);
    wr(8'h24, 32'h4);
    rd(8'h20, r); check("R11 aborted status", r, 32'hC);
    rd(8'h10, r); check("R11 ring-op on abort", r, 32'h400);
    done_pulse(1'b0, 1'b0);
    rd(8'h2C, r); check("R11 halted while aborted", r, 32'h2);
    wr(8'h10, 32'h400);
    wr(8'h24, 32'h1);
    rd(8'h20, r); check("R11 restarted", r, 32'h3);
    done_pulse(1'b0, 1'b0);
    rd(8'h2C, r); check("R11 runs after restart", r, 32'h3);
    rd(8'h10, r); check("R11 ring-op on restart", r, 32'h400);
    wr(8'h10, 32'h400);

    // R13 record ring, entry count 4
    push_pulse();
    rd(8'h2C, r); check("R13 record push", r, 32'h0001_0003);
    rd(8'h10, r); check("R13 ready bit", r, 32'h1000);
    push_pulse();
    push_pulse();
    push_pulse();
    rd(8'h2C, r); check("R13 full drop", r, 32'h0003_0003);
    rd(8'h10, r); check("R13 full bit", r, 32'h1040);
    wr(8'h28, 32'h0003_0003);
    rd(8'h28, r); check("R3 record deq field", r, 32'h0003_0003);
    push_pulse();
    rd(8'h2C, r); check("R13 record wrap", r, 32'h0000_0003);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule